// File: doc/BRIEF.md
# Block-Transfer Command Port Decoder

This block sits on a 16-bit processor I/O bus and turns three I/O port writes into the control signals that a block-transfer engine needs. Two ports assemble a 21-bit byte address, which covers 2 MB of external SDRAM. The third port takes a command word. That word launches one 128-byte block move, sets its direction and can flip which of the two staging buffers faces the processor.

Software loads the address first. For a write to memory it fills the staging buffer before that; for a read it drains the buffer afterwards. It then writes the command port and polls the same port until the ready bit returns. A bus write is captured on the clock after the rising edge of the I/O strobe, provided chip select is low and the bus direction is write. The strobe is synchronous to `clk`.

Top module: `xfer_port_decoder`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `mem_addr` is 0, `ready` is 1, `mem_rd` is 0, `buf_swap` is 0, and `xfer_start` and `addr_reset` are 0.
- R2: A captured write to port 0x0003 loads `bus_wdata[4:0]` into `mem_addr[20:16]`, visible one clock after the strobe rising edge is sampled; `mem_addr[15:0]` is kept.
- R3: A captured write to port 0x0004 loads `bus_wdata[15:0]` into `mem_addr[15:0]` and raises `addr_reset` for exactly one clock, both in the same cycle.
- R4: A write is not captured if chip select is high, `bus_rd` is 1, the address is some other port, or the strobe stays high with no new rising edge; `mem_addr` then keeps its value.
- R5: A captured write to port 0x0005 while `ready` is 1 raises `xfer_start` for exactly one clock, clears `ready`, and sets `mem_rd` to `bus_wdata[0]` (1 = read from memory, 0 = write to memory), all one clock after the edge is sampled.
- R6: When a command is accepted and `bus_wdata[1]` is 1, `buf_swap` toggles in the same cycle as `xfer_start`; with bit 1 at 0 it keeps its value.
- R7: A command written while `ready` is 0 is ignored: no `xfer_start`, and `mem_rd` and `buf_swap` are unchanged.
- R8: A `xfer_done` pulse sampled while `ready` is 0 sets `ready` on the next clock.
- R9: `bus_rdata` is combinational. With chip select low, `bus_rd` at 1 and the address at 0x0005, bit 0 is `ready` and bits 15..1 are 0. Every other read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_n | input | 1 | I/O chip select, active low |
| bus_addr | input | 16 | I/O port address |
| bus_wdata | input | 16 | Write data from processor |
| bus_rd | input | 1 | Bus direction, 1 = read |
| bus_strobe | input | 1 | I/O strobe; writes are taken on its rising edge |
| xfer_done | input | 1 | One-clock pulse from the transfer engine when a block finishes |
| bus_rdata | output | 16 | Read data (status) |
| mem_addr | output | 21 | Byte address of the block in memory |
| mem_rd | output | 1 | Direction of the block move, 1 = memory to buffer |
| xfer_start | output | 1 | One-clock start pulse |
| addr_reset | output | 1 | One-clock pulse when the low address part is loaded |
| buf_swap | output | 1 | Staging buffer selection level |
| ready | output | 1 | High when no block move is pending |

## Verification
The bench drives address loads in both orders and with varied data, then commands of each direction with and without the swap bit. These runs separate the high and low address fields and show that the direction and swap bits are decoded independently. Writes made with chip select off, with the read direction, to a neighbouring port, or with the strobe held high test whether only a true strobe edge is taken. Commands sent while busy, `xfer_done` pulses sent while idle, and status reads on several ports test the ready handshake that software polls.

// File: rtl/xfer_port_decoder.sv
module xfer_port_decoder #(
  parameter int IO_W      = 16,
  parameter int MADDR_W   = 21,
  parameter int PORT_HI   = 16'h0003,
  parameter int PORT_LO   = 16'h0004,
  parameter int PORT_CMD  = 16'h0005,
  localparam int HI_W     = MADDR_W - IO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_cs_n,
  input  logic [IO_W-1:0]    bus_addr,
  input  logic [IO_W-1:0]    bus_wdata,
  input  logic               bus_rd,
  input  logic               bus_strobe,
  input  logic               xfer_done,
  output logic [IO_W-1:0]    bus_rdata,
  output logic [MADDR_W-1:0] mem_addr,
  output logic               mem_rd,
  output logic               xfer_start,
  output logic               addr_reset,
  output logic               buf_swap,
  output logic               ready
);

  logic strobe_q;
  logic wr_edge;
  logic hit_hi, hit_lo, hit_cmd;
  logic accept;

  assign wr_edge = bus_strobe & ~strobe_q & ~bus_cs_n & ~bus_rd;
  assign hit_hi  = wr_edge && (bus_addr == IO_W'(PORT_HI));
  assign hit_lo  = wr_edge && (bus_addr == IO_W'(PORT_LO));
  assign hit_cmd = wr_edge && (bus_addr == IO_W'(PORT_CMD));
  assign accept  = hit_cmd & ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q   <= 1'b0;
      mem_addr   <= '0;
      mem_rd     <= 1'b0;
      xfer_start <= 1'b0;
      addr_reset <= 1'b0;
      buf_swap   <= 1'b0;
      ready      <= 1'b1;
    end else begin
      strobe_q   <= bus_strobe;
      xfer_start <= accept;
      addr_reset <= hit_lo;
      if (hit_hi) mem_addr[MADDR_W-1:IO_W] <= bus_wdata[HI_W-1:0];
      if (hit_lo) mem_addr[IO_W-1:0]       <= bus_wdata;
      if (accept) begin
        mem_rd   <= bus_wdata[0];
        buf_swap <= buf_swap ^ bus_wdata[1];
        ready    <= 1'b0;
      end else if (xfer_done) begin
        ready    <= 1'b1;
      end
    end
  end

  assign bus_rdata = (!bus_cs_n && bus_rd && bus_addr == IO_W'(PORT_CMD))
                     ? {{(IO_W-1){1'b0}}, ready} : '0;

endmodule

// File: rtl/xfer_port_decoder_chk.sv
module xfer_port_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic xfer_done,
  input logic xfer_start,
  input logic addr_reset,
  input logic buf_swap,
  input logic mem_rd,
  input logic ready
);

  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !ready);

  assert_addr_reset_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_reset |=> !addr_reset);

  assert_swap_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(rst_n) && !$stable(buf_swap)) |-> xfer_start);

  assert_dir_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(rst_n) && !$stable(mem_rd)) |-> xfer_start);

  assert_ready_by_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(rst_n) && $rose(ready)) |-> $past(xfer_done));

endmodule

bind xfer_port_decoder xfer_port_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .xfer_start(xfer_start),
  .addr_reset(addr_reset), .buf_swap(buf_swap), .mem_rd(mem_rd), .ready(ready)
);

// File: tb/xfer_port_decoder_test.sv
module xfer_port_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs_n = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic        bus_strobe = 1'b0;
  logic        xfer_done = 1'b0;
  logic [15:0] bus_rdata;
  logic [20:0] mem_addr;
  logic        mem_rd, xfer_start, addr_reset, buf_swap, ready;

  int checks = 0;
  int errors = 0;
  int start_count = 0;

  logic [20:0] m_addr = '0;
  logic        m_rd = 1'b0, m_start = 1'b0, m_arst = 1'b0, m_swap = 1'b0, m_ready = 1'b1;
  logic        m_strb = 1'b0;
  bit          cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_port_decoder uut (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_strobe(bus_strobe),
    .xfer_done(xfer_done), .bus_rdata(bus_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .xfer_start(xfer_start), .addr_reset(addr_reset),
    .buf_swap(buf_swap), .ready(ready)
  );

  // behavioural reference, updated on the same edge as the design
  always @(posedge clk) begin
    bit wr;
    wr = bus_strobe && !m_strb && !bus_cs_n && !bus_rd;
    if (!rst_n) begin
      m_addr = '0; m_rd = 0; m_start = 0; m_arst = 0; m_swap = 0; m_ready = 1; m_strb = 0;
    end else begin
      m_strb  = bus_strobe;
      m_start = 0;
      m_arst  = 0;
      if (wr && bus_addr == 16'h0003) m_addr[20:16] = bus_wdata[4:0];
      if (wr && bus_addr == 16'h0004) begin m_addr[15:0] = bus_wdata; m_arst = 1; end
      if (wr && bus_addr == 16'h0005 && m_ready) begin
        m_rd = bus_wdata[0];
        if (bus_wdata[1]) m_swap = !m_swap;
        m_start = 1; m_ready = 0;
      end else if (xfer_done) m_ready = 1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (xfer_start === 1'b1) start_count++;
    if (cmp_on) begin
      check("R2/R3 mem_addr", 32'(mem_addr), 32'(m_addr));
      check("R3 addr_reset", 32'(addr_reset), 32'(m_arst));
      check("R5 xfer_start", 32'(xfer_start), 32'(m_start));
      check("R5 mem_rd", 32'(mem_rd), 32'(m_rd));
      check("R6 buf_swap", 32'(buf_swap), 32'(m_swap));
      check("R8 ready", 32'(ready), 32'(m_ready));
      check("R9 bus_rdata", 32'(bus_rdata),
            (!bus_cs_n && bus_rd && bus_addr == 16'h0005) ? 32'(m_ready) : 32'h0);
    end
  end

  task automatic io_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_cs_n = 0; bus_rd = 0; bus_addr = a; bus_wdata = d; bus_strobe = 1;
    @(negedge clk);
    bus_strobe = 0; bus_cs_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
    @(negedge clk);
  endtask

  task automatic read_status(input logic [15:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    bus_cs_n = 0; bus_rd = 1; bus_addr = a;
    #1 check(req, 32'(bus_rdata), 32'(exp));
    @(negedge clk);
    bus_cs_n = 1; bus_rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int sc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 mem_addr", 32'(mem_addr), 0);
    check("R1 ready", 32'(ready), 1);
    check("R1 mem_rd", 32'(mem_rd), 0);
    check("R1 buf_swap", 32'(buf_swap), 0);
    check("R1 start/arst", {30'b0, xfer_start, addr_reset}, 0);
    cmp_on = 1;

    io_write(16'h0003, 16'hFFF5);
    check("R2 high field", 32'(mem_addr), 32'h150000);
    io_write(16'h0004, 16'hBEEF);
    check("R3 low field", 32'(mem_addr), 32'h15BEEF);
    io_write(16'h0003, 16'h000A);
    check("R2 high keeps low", 32'(mem_addr), 32'h0ABEEF);

    // R4 uncaptured writes
    @(negedge clk); bus_cs_n = 1; bus_rd = 0; bus_addr = 16'h0004; bus_wdata = 16'h1111; bus_strobe = 1;
    @(negedge clk); bus_strobe = 0; @(negedge clk);
    @(negedge clk); bus_cs_n = 0; bus_rd = 1; bus_addr = 16'h0003; bus_wdata = 16'h001F; bus_strobe = 1;
    @(negedge clk); bus_strobe = 0; bus_cs_n = 1; bus_rd = 0; @(negedge clk);
    io_write(16'h0006, 16'h2222);
    io_write(16'h0002, 16'h3333);
    check("R4 ignored writes", 32'(mem_addr), 32'h0ABEEF);
    // strobe held high: only one capture
    @(negedge clk); bus_cs_n = 0; bus_rd = 0; bus_addr = 16'h0004; bus_wdata = 16'h1234; bus_strobe = 1;
    @(negedge clk); bus_wdata = 16'h5678;
    @(negedge clk); bus_wdata = 16'h9ABC;
    @(negedge clk); bus_strobe = 0; bus_cs_n = 1; @(negedge clk);
    check("R4 held strobe", 32'(mem_addr), 32'h0A1234);

    read_status(16'h0005, 16'h0001, "R9 idle status");
    read_status(16'h0004, 16'h0000, "R9 other port");

    // R5 read command with swap
    sc = start_count;
    io_write(16'h0005, 16'h0003);
    check("R5 one start", 32'(start_count - sc), 1);
    check("R5 direction read", 32'(mem_rd), 1);
    check("R6 swap toggled", 32'(buf_swap), 1);
    read_status(16'h0005, 16'h0000, "R9 busy status");

    // R7 command while busy ignored
    sc = start_count;
    io_write(16'h0005, 16'h0002);
    check("R7 no start", 32'(start_count - sc), 0);
    check("R7 dir kept", 32'(mem_rd), 1);
    check("R7 swap kept", 32'(buf_swap), 1);

    pulse_done();
    check("R8 ready back", 32'(ready), 1);
    pulse_done();
    check("R8 done while idle", 32'(ready), 1);

    // write command without swap
    io_write(16'h0005, 16'h0000);
    check("R5 direction write", 32'(mem_rd), 0);
    check("R6 swap unchanged", 32'(buf_swap), 1);
    pulse_done();
    io_write(16'h0005, 16'h0002);
    check("R6 swap back", 32'(buf_swap), 0);
    // done on the same clock as a busy command
    @(negedge clk); bus_cs_n = 0; bus_rd = 0; bus_addr = 16'h0005; bus_wdata = 16'h0001; bus_strobe = 1; xfer_done = 1;
    @(negedge clk); bus_strobe = 0; bus_cs_n = 1; xfer_done = 0; @(negedge clk);
    check("R7 busy command + done", 32'(mem_rd), 0);
    check("R8 ready after done", 32'(ready), 1);

    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    check("R1 reset again", 32'(mem_addr), 0);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule